// File: doc/BRIEF.md
# Standby Regulator Soft-Start and Fault Retry Controller

This controller drives the enable and the digital reference ramp of an on-chip standby 3.3V linear regulator. After the standby supply reports good, it waits one soft-start interval. It then enables the regulator and raises a reference code from zero to full scale in equal steps across one more interval. When the code reaches full scale it raises a done flag.

Two digital flags come from comparators outside the block: undervoltage and over-temperature. Undervoltage counts only while the regulator has finished ramping and the system is in a sleep state. It must also be seen on two consecutive clock edges. Each qualified undervoltage event turns the regulator off, waits one interval and ramps it again. The fourth event latches the regulator off, and only a power-on reset releases it. Over-temperature drops the regulator at once without using up a retry. The block restarts from the power-good wait once the flag clears.

Top module: `sbreg_ss_ctrl`

## Requirements
- R1: While `por_n` is low, `reg_en`, `ramp_code`, `ramp_done` and `fault_latched` are all 0.
- R2: After `stby_good` is sampled high in the idle state, `reg_en` rises exactly INTERVAL = (2^CODE_W-1)*TICK_DIV clock edges later. `ramp_code` stays 0 until then.
- R3: Once enabled, `ramp_code` rises by exactly 1 every TICK_DIV edges. It reaches full scale (all ones) INTERVAL edges after the enable, and `ramp_done` goes high on that same edge.
- R4: If `stby_good` is low (and no fault is latched), the block is off: `reg_en`, `ramp_code` and `ramp_done` are 0. When it returns high, the sequence of R2 and R3 starts again.
- R5: `uv_flag` has no effect while the wait or the ramp is in progress, or while `in_sleep` is 0.
- R6: An undervoltage event needs `uv_flag` high on two consecutive rising edges. A one-cycle pulse is ignored.
- R7: A qualified event clears `reg_en`, `ramp_code` and `ramp_done` on the second of those edges. After INTERVAL more edges a fresh ramp begins, and it behaves as in R3.
- R8: Successful ramps do not clear the retry count. Three events are each followed by a retry. The fourth sets `fault_latched` and holds the regulator off, whatever `stby_good` does, until `por_n` is asserted.
- R9: `ot_flag` high turns the regulator off on the next edge and does not count as a retry. When it clears, the sequence of R2 and R3 restarts.
- R10: While enabled, `ramp_code` never decreases and never changes by more than one step per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| stby_good | input | 1 | Standby supply power-good |
| in_sleep | input | 1 | High while the system is in a sleep state |
| uv_flag | input | 1 | Regulator output undervoltage comparator |
| ot_flag | input | 1 | Over-temperature comparator |
| reg_en | output | 1 | Regulator enable |
| ramp_code | output | CODE_W | Soft-start reference code |
| ramp_done | output | 1 | Ramp complete, code at full scale |
| fault_latched | output | 1 | Regulator latched off after the fourth undervoltage |

## Verification
The embedded assertions check, on every cycle, that the ramp code only climbs one step at a time while enabled. They also check that done implies full scale with the enable on, and that a latched fault keeps the regulator off and cannot clear without reset. Only the bench scenarios can show exact interval lengths, step timing, and whether undervoltage is ignored during ramps, outside sleep or for a single cycle. The same holds for the count of four events before the latch and for over-temperature not using up a retry. The bench sweeps every cycle of each power-up and retry window and checks each one against values computed from the interval arithmetic.

// File: rtl/sbreg_ss_ctrl.sv
module sbreg_ss_ctrl #(
  parameter int CODE_W   = 6,
  parameter int TICK_DIV = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              stby_good,
  input  logic              in_sleep,
  input  logic              uv_flag,
  input  logic              ot_flag,
  output logic              reg_en,
  output logic [CODE_W-1:0] ramp_code,
  output logic              ramp_done,
  output logic              fault_latched
);
  localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};
  localparam int INTERVAL = ((1 << CODE_W) - 1) * TICK_DIV;
  localparam int CNT_W = $clog2(INTERVAL + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INTERVAL - 1);
  localparam logic [CNT_W-1:0] TICK_LAST = CNT_W'(TICK_DIV - 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_RAMP, S_ON, S_RETRY, S_LATCH} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       retries;
  logic             uv_q;
  logic             uv_evt;

  assign uv_evt        = (st == S_ON) && in_sleep && uv_flag && uv_q;
  assign reg_en        = (st == S_RAMP) || (st == S_ON);
  assign ramp_done     = (st == S_ON);
  assign fault_latched = (st == S_LATCH);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      ramp_code <= '0;
      retries   <= '0;
      uv_q      <= 1'b0;
    end else begin
      uv_q <= uv_flag;
      if (st == S_LATCH) begin
        ramp_code <= '0;
      end else if (!stby_good || ot_flag) begin
        st        <= S_IDLE;
        cnt       <= '0;
        ramp_code <= '0;
      end else begin
        case (st)
          S_IDLE: begin
            st  <= S_WAIT;
            cnt <= '0;
          end
          S_WAIT, S_RETRY: begin
            if (cnt == CNT_LAST) begin
              st  <= S_RAMP;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_RAMP: begin
            if (cnt == TICK_LAST) begin
              cnt       <= '0;
              ramp_code <= ramp_code + 1'b1;
              if (ramp_code == FULL - 1'b1) st <= S_ON;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_ON: begin
            if (uv_evt) begin
              ramp_code <= '0;
              cnt       <= '0;
              if (retries == 2'd3) begin
                st <= S_LATCH;
              end else begin
                retries <= retries + 1'b1;
                st      <= S_RETRY;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R10
  code_mono_chk: assert property (@(posedge clk) disable iff (!por_n)
    (reg_en && $past(reg_en)) |-> (ramp_code >= $past(ramp_code)));

  // R10
  code_step_chk: assert property (@(posedge clk) disable iff (!por_n)
    (reg_en && $past(reg_en) && ramp_code != $past(ramp_code))
      |-> (ramp_code == $past(ramp_code) + 1'b1));

  // R3
  done_full_chk: assert property (@(posedge clk) disable iff (!por_n)
    ramp_done |-> (ramp_code == FULL && reg_en));

  // R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    fault_latched |=> fault_latched);

  // R8
  latch_off_chk: assert property (@(posedge clk) disable iff (!por_n)
    fault_latched |-> (!reg_en && ramp_code == '0));

  // R9
  ot_off_chk: assert property (@(posedge clk) disable iff (!por_n)
    ot_flag |=> !reg_en);
endmodule

// File: tb/sbreg_ss_ctrl_tb.sv
`timescale 1ns/1ps
module sbreg_ss_ctrl_tb;
  localparam int CW = 3;
  localparam int TD = 2;
  localparam int FULLV = (1 << CW) - 1;
  localparam int IV = FULLV * TD;

  logic clk = 0, por_n = 0, stby_good = 0, in_sleep = 0, uv_flag = 0, ot_flag = 0;
  logic reg_en, ramp_done, fault_latched;
  logic [CW-1:0] ramp_code;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sbreg_ss_ctrl #(.CODE_W(CW), .TICK_DIV(TD)) u_dut (
    .clk(clk), .por_n(por_n), .stby_good(stby_good), .in_sleep(in_sleep),
    .uv_flag(uv_flag), .ot_flag(ot_flag), .reg_en(reg_en), .ramp_code(ramp_code),
    .ramp_done(ramp_done), .fault_latched(fault_latched));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Called just before the edge that starts the wait (or retry) window.
  // n = edges after that edge; samples n = 0..2*IV.
  task automatic sweep(input string req, input bit hold_uv);
    for (int n = 0; n <= 2 * IV; n++) begin
      @(negedge clk);
      if (!hold_uv) uv_flag = 0;
      chk({req, " R2 en"}, reg_en, n >= IV);
      chk({req, " R3 code"}, ramp_code, (n < IV) ? 0 : (((n - IV) / TD > FULLV) ? FULLV : (n - IV) / TD));
      chk({req, " R3 done"}, ramp_done, n >= 2 * IV);
      chk({req, " R8 nolatch"}, fault_latched, 0);
    end
    uv_flag = 0;
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    in_sleep = 1;
    stby_good = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 en", reg_en, 0);
    chk("R1 code", ramp_code, 0);
    chk("R1 done", ramp_done, 0);
    chk("R1 latch", fault_latched, 0);
    stby_good = 0;
    @(negedge clk);
    por_n = 1;
    @(negedge clk);
    chk("R4 idle en", reg_en, 0);
    // Power-up with UV held high through wait and ramp: R2 R3 R5
    stby_good = 1;
    uv_flag = 1;
    sweep("R5 uv-during-ramp", 1);

    // R5: UV outside sleep ignored
    in_sleep = 0;
    uv_flag = 1;
    repeat (6) @(negedge clk);
    chk("R5 nosleep done", ramp_done, 1);
    chk("R5 nosleep en", reg_en, 1);
    uv_flag = 0;
    in_sleep = 1;
    @(negedge clk);

    // R6: one-cycle UV pulse ignored
    uv_flag = 1;
    @(negedge clk);
    uv_flag = 0;
    repeat (4) @(negedge clk);
    chk("R6 pulse done", ramp_done, 1);
    chk("R6 pulse code", ramp_code, FULLV);

    // R4: power-good loss
    stby_good = 0;
    @(negedge clk);
    chk("R4 off en", reg_en, 0);
    chk("R4 off code", ramp_code, 0);
    chk("R4 off done", ramp_done, 0);
    @(negedge clk);
    stby_good = 1;
    sweep("R4 restart", 0);

    // R9: over-temperature
    ot_flag = 1;
    @(negedge clk);
    chk("R9 ot en", reg_en, 0);
    chk("R9 ot code", ramp_code, 0);
    repeat (IV + 3) @(negedge clk);
    chk("R9 ot hold", reg_en, 0);
    ot_flag = 0;
    sweep("R9 ot restart", 0);

    // R7: three retries, each a full wait+ramp
    for (int r = 0; r < 3; r++) begin
      uv_flag = 1;
      @(negedge clk);
      chk("R6 first edge", reg_en, 1);
      sweep("R7 retry", 0);
    end

    // R8: fourth event latches
    uv_flag = 1;
    @(negedge clk);
    @(negedge clk);
    uv_flag = 0;
    chk("R8 latch", fault_latched, 1);
    chk("R8 latch en", reg_en, 0);
    chk("R8 latch code", ramp_code, 0);
    chk("R8 latch done", ramp_done, 0);
    stby_good = 0;
    repeat (3) @(negedge clk);
    stby_good = 1;
    repeat (3 * IV) @(negedge clk);
    chk("R8 stays latched", fault_latched, 1);
    chk("R8 stays off", reg_en, 0);

    // R8/R1: only POR clears
    por_n = 0;
    @(negedge clk);
    chk("R1 por latch", fault_latched, 0);
    chk("R1 por en", reg_en, 0);
    por_n = 1;
    sweep("R8 post-por", 0);
    finish_up();
  end
endmodule